// File: doc/BRIEF.md
# General-Purpose Register File with Same-Cycle Write Visibility

This block holds the integer architectural registers of a five-stage in-order pipeline: 32 entries of 32 bits each. The decode stage reads two source operands through two combinational read ports. The addresses for those ports come straight from the fixed source-register fields of the instruction word, so operand lookup can begin before the opcode has been decoded. The write-back stage commits one result per cycle through a separate synchronous write port. Because reads and writes use separate ports, they never compete for one.

A result committed by write-back is visible to decode in the same cycle. When the write enable is high and the write address matches a read address, that read port returns the incoming write data instead of the stored word. This gives decode the effect of a write in the first half of the cycle and a read in the second half, using a single clock edge. Entry zero is hard-wired: it always reads as zero and ignores writes, and the same-cycle path never applies to it. A synchronous reset clears every entry.

Top module: `gpr_file`

## Requirements
- R1: On the first rising edge with `rst` high, every entry is cleared. After that edge, both read ports return 0 for every address.
- R2: A rising edge with `wr_en` high and a nonzero `wr_addr` stores `wr_data` into that entry. Any later read of the entry returns the stored word until it is written again.
- R3: A rising edge with `wr_en` low changes no entry, whatever `wr_addr` and `wr_data` hold.
- R4: While `wr_en` is high, `wr_addr` is nonzero and `wr_addr` equals `rd_addr_a`, `rd_data_a` equals `wr_data` within the same cycle, before the edge.
- R5: While `wr_en` is high, `wr_addr` is nonzero and `wr_addr` equals `rd_addr_b`, `rd_data_b` equals `wr_data` within the same cycle, before the edge.
- R6: A read port whose address differs from a pending write address returns the stored contents of its own entry, unaffected by the pending write.
- R7: Address 0 reads as 0 on both ports at all times. A write to address 0 is discarded and triggers no same-cycle forwarding.
- R8: The two read ports are independent. Both may address the same entry and then return the same value.
- R9: Reset asserted after entries have been written clears them all to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset take effect on the rising edge |
| rst | input | 1 | Synchronous reset, active high; clears all entries |
| wr_en | input | 1 | Write-back commit enable |
| wr_addr | input | 5 | Destination entry of the write |
| wr_data | input | 32 | Result word to be written |
| rd_addr_a | input | 5 | First source entry (first source field) |
| rd_data_a | output | 32 | First operand, combinational |
| rd_addr_b | input | 5 | Second source entry (second source field) |
| rd_data_b | output | 32 | Second operand, combinational |

## Verification
Directed cycles cover several cases that each separate one behaviour from the others:
- A write whose address matches port A only, port B only, or both ports. These show whether forwarding is wired per port.
- A write alongside reads of other addresses. This tells forwarding apart from an address-blind override.
- A write with enable low. This tells stored contents apart from pending data.
- Writes and reads at address zero. These show whether the hard-wired entry is respected on both the storage path and the forwarding path.

Seeded random traffic, biased so that read addresses often equal the write address, then mixes all of these cases against a bench-side model of the register contents.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
    localparam int unsigned GPR_AW = 5;
    localparam int unsigned GPR_DW = 32;
    localparam int unsigned GPR_N  = 1 << GPR_AW;
    localparam int unsigned GPR_RD = 2;

    typedef logic [GPR_AW-1:0] gpr_idx_t;
    typedef logic [GPR_DW-1:0] gpr_word_t;
    // entry zero is never stored
    typedef gpr_word_t [GPR_N-1:1] gpr_bank_t;

    typedef struct packed {
        gpr_bank_t bank;
    } gpr_state_t;
endpackage

// File: rtl/gpr_store.sv
module gpr_store
    import gpr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  gpr_idx_t  wr_addr,
    input  gpr_word_t wr_data,
    output gpr_bank_t bank
);
    gpr_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en && (wr_addr != '0)) begin
            for (int i = 1; i < int'(GPR_N); i++) begin
                if (wr_addr == gpr_idx_t'(i)) begin
                    state_d.bank[i] = wr_data;
                end
            end
        end
        if (rst) begin
            state_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign bank = state_q.bank;
endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port
    import gpr_pkg::*;
(
    input  gpr_bank_t bank,
    input  logic      wr_en,
    input  gpr_idx_t  wr_addr,
    input  gpr_word_t wr_data,
    input  gpr_idx_t  rd_addr,
    output gpr_word_t rd_data
);
    logic      fwd_hit;
    gpr_word_t stored;

    always_comb begin
        stored = '0;
        for (int i = 1; i < int'(GPR_N); i++) begin
            if (rd_addr == gpr_idx_t'(i)) begin
                stored = bank[i];
            end
        end
    end

    assign fwd_hit = wr_en && (wr_addr == rd_addr) && (rd_addr != '0);

    always_comb begin
        if (rd_addr == '0) begin
            rd_data = '0;
        end else if (fwd_hit) begin
            rd_data = wr_data;
        end else begin
            rd_data = stored;
        end
    end
endmodule

// File: rtl/gpr_file.sv
module gpr_file
    import gpr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [GPR_AW-1:0] wr_addr,
    input  logic [GPR_DW-1:0] wr_data,
    input  logic [GPR_AW-1:0] rd_addr_a,
    output logic [GPR_DW-1:0] rd_data_a,
    input  logic [GPR_AW-1:0] rd_addr_b,
    output logic [GPR_DW-1:0] rd_data_b
);
    gpr_bank_t bank;
    gpr_idx_t  rd_addr_v [GPR_RD];
    gpr_word_t rd_data_v [GPR_RD];

    assign rd_addr_v[0] = rd_addr_a;
    assign rd_addr_v[1] = rd_addr_b;
    assign rd_data_a    = rd_data_v[0];
    assign rd_data_b    = rd_data_v[1];

    gpr_store u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .bank    (bank)
    );

    for (genvar p = 0; p < int'(GPR_RD); p++) begin : g_rd
        gpr_read_port u_port (
            .bank    (bank),
            .wr_en   (wr_en),
            .wr_addr (wr_addr),
            .wr_data (wr_data),
            .rd_addr (rd_addr_v[p]),
            .rd_data (rd_data_v[p])
        );
    end
endmodule

// File: rtl/gpr_file_chk.sv
module gpr_file_chk
    import gpr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [GPR_AW-1:0] wr_addr,
    input logic [GPR_DW-1:0] wr_data,
    input logic [GPR_AW-1:0] rd_addr_a,
    input logic [GPR_DW-1:0] rd_data_a,
    input logic [GPR_AW-1:0] rd_addr_b,
    input logic [GPR_DW-1:0] rd_data_b
);
    logic armed_q;

    always_ff @(posedge clk) begin
        armed_q <= !rst;
    end

    assert_zero_a_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_addr_a == '0) |-> (rd_data_a == '0));

    assert_zero_b_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_addr_b == '0) |-> (rd_data_b == '0));

    assert_fwd_a_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != '0 && wr_addr == rd_addr_a) |-> (rd_data_a == wr_data));

    assert_fwd_b_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != '0 && wr_addr == rd_addr_b) |-> (rd_data_b == wr_data));

    assert_commit_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != '0) |=> (armed_q && rd_addr_a == $past(wr_addr)
            && !(wr_en && wr_addr == rd_addr_a)) -> (rd_data_a == $past(wr_data)));

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (armed_q && !$past(wr_en) && !wr_en && $stable(rd_addr_b)) |-> $stable(rd_data_b));
endmodule

bind gpr_file gpr_file_chk u_chk (.*);

// File: tb/tb_gpr_file.sv
`timescale 1ns/1ps
module tb_gpr_file;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_addr_a = '0;
    logic [31:0] rd_data_a;
    logic [4:0]  rd_addr_b = '0;
    logic [31:0] rd_data_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] mdl [32];

    always #2 clk = ~clk;

    gpr_file dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b)
    );

    function automatic logic [31:0] exp_rd(input logic [4:0] ra, input logic we,
                                           input logic [4:0] wa, input logic [31:0] wd);
        if (ra == 5'd0) return 32'd0;
        if (we && wa == ra) return wd;
        return mdl[ra];
    endfunction

    function automatic string tag_for(input logic [4:0] ra, input logic we,
                                      input logic [4:0] wa, input bit port_b);
        if (ra == 5'd0) return "R7";
        if (we && wa == ra) return port_b ? "R5" : "R4";
        if (we) return "R6";
        return "R2";
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic we, input logic [4:0] wa, input logic [31:0] wd,
                       input logic [4:0] ra, input logic [4:0] rb,
                       input string ta, input string tb);
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd;
        rd_addr_a = ra; rd_addr_b = rb;
        #1;
        chk(ta, rd_data_a, exp_rd(ra, we, wa, wd));
        chk(tb, rd_data_b, exp_rd(rb, we, wa, wd));
        @(posedge clk);
        if (we && wa != 5'd0) mdl[wa] = wd;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0;
        @(posedge clk);
        for (int i = 0; i < 32; i++) mdl[i] = 32'd0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) mdl[i] = 32'd0;
        do_reset();
        // R1: everything reads zero after reset
        for (int i = 0; i < 32; i++) cyc(1'b0, 5'd0, 32'd0, 5'(i), 5'(31 - i), "R1", "R1");
        // R2: commit then read back
        cyc(1'b1, 5'd5, 32'hAAAA_0005, 5'd1, 5'd2, "R6", "R6");
        cyc(1'b0, 5'd0, 32'd0, 5'd5, 5'd5, "R2", "R8");
        // R3: enable low leaves entry alone
        cyc(1'b0, 5'd5, 32'hDEAD_BEEF, 5'd5, 5'd3, "R3", "R3");
        cyc(1'b0, 5'd0, 32'd0, 5'd3, 5'd5, "R3", "R3");
        // R4: same-cycle forwarding on port A
        cyc(1'b1, 5'd9, 32'h1234_5678, 5'd9, 5'd5, "R4", "R6");
        // R5: same-cycle forwarding on port B
        cyc(1'b1, 5'd10, 32'h8765_4321, 5'd5, 5'd10, "R6", "R5");
        // R4/R5 together, overwrite of an existing entry
        cyc(1'b1, 5'd5, 32'h0F0F_F0F0, 5'd5, 5'd5, "R4", "R5");
        // R6: different addresses keep stored values
        cyc(1'b1, 5'd31, 32'hFFFF_FFFF, 5'd9, 5'd10, "R6", "R6");
        cyc(1'b0, 5'd0, 32'd0, 5'd31, 5'd5, "R2", "R2");
        // R7: writes to entry zero discarded, no forwarding
        cyc(1'b1, 5'd0, 32'hCAFE_F00D, 5'd0, 5'd0, "R7", "R7");
        cyc(1'b0, 5'd0, 32'd0, 5'd0, 5'd0, "R7", "R7");
        // R9: reset after writes clears
        do_reset();
        for (int i = 0; i < 32; i++) cyc(1'b0, 5'd0, 32'd0, 5'(i), 5'(i), "R9", "R9");

        // random traffic with fixed seed
        void'($urandom(32'h5EED_0343));
        for (int n = 0; n < 3000; n++) begin
            logic we; logic [4:0] wa, ra, rb; logic [31:0] wd;
            we = 1'($urandom % 4 != 0);
            wa = 5'($urandom);
            wd = $urandom;
            ra = ($urandom % 3 == 0) ? wa : 5'($urandom);
            rb = ($urandom % 3 == 0) ? wa : 5'($urandom);
            if ($urandom % 16 == 0) wa = 5'd0;
            cyc(we, wa, wd, ra, rb, tag_for(ra, we, wa, 1'b0), tag_for(rb, we, wa, 1'b1));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule